// File: doc/BRIEF.md
# Packet Commit Writer for a Slave FIFO

This block handles the write side of a slave FIFO. An external master writes bytes, one per interface clock edge, by raising a write strobe. The block does not store the data bytes. It counts the bytes of the packet being built and closes that packet in one of two ways, then pushes a length descriptor into a small packet queue. A packet closes by itself on the write that brings its byte count up to a programmable auto-length. The master can also close it early by raising a packet-end strobe, which sends a short packet. That short packet may hold a single byte or no bytes at all.

The two ways of closing a packet can collide. This happens when packet-end is raised at the same clock edge as the write that completes an automatic packet. In that case the manual commit is dropped, not merged into the packet, and a sticky error flag is raised. A packet-end raised one cycle later or afterwards works normally. Registered empty and full flags report the state of the queue. A read side pops descriptors, and the oldest descriptor's length is always visible.

Top module: `pkt_commit_writer`

## Requirements
- R1: While reset is held and right after it, `q_empty` is 1, `q_full` is 0 and `late_err` is 0.
- R2: A write that brings the pending byte count up to the auto-length X commits a packet of length X and clears the count.
- R3: `pkt_end` commits all pending bytes as a short packet. A write in the same cycle is included in that packet, so a single byte can be committed on its own.
- R4: `pkt_end` with no bytes pending and no write in that cycle commits a packet of length 0.
- R5: If `pkt_end` arrives in the same cycle as a write that completes an automatic packet, only the automatic packet is committed and `late_err` is set. `late_err` then stays set until reset. A `pkt_end` one cycle after the completing write commits normally.
- R6: While `q_full` is 1, no commit of either kind takes place. A manual commit is ignored and the pending bytes stay pending. A write that would complete an automatic packet is ignored. Writes that do not complete a packet are still counted.
- R7: `q_full` is 1 exactly when the queue holds QDEPTH descriptors, and `q_empty` is 1 exactly when it holds none. Both flags change in the cycle after the edge that commits or pops.
- R8: The auto-length input is taken only while no bytes are pending. A change made while a packet is partly written takes effect from the next packet. The value 0 acts as 1.
- R9: `desc_len` shows the length of the oldest committed packet. `rd_pop` while the queue is not empty removes that packet, and packets leave in commit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per edge |
| pkt_end | input | 1 | Manual packet-end strobe |
| auto_len | input | LEN_W | Automatic packet length, 1 to 1024 |
| rd_pop | input | 1 | Removes the oldest descriptor |
| desc_len | output | LEN_W | Length of the oldest descriptor |
| q_empty | output | 1 | Queue holds no descriptor (registered) |
| q_full | output | 1 | Queue holds QDEPTH descriptors (registered) |
| late_err | output | 1 | Sticky flag for a dropped early packet-end |

## Verification
Both commit paths can fire in the same cycle. This happens when `pkt_end` arrives together with the write that brings the count up to the auto-length. The bench provokes it by writing X-1 bytes and then driving the completing write and `pkt_end` together. It then expects exactly one descriptor of length X, an empty queue after that descriptor is popped, and `late_err` set. The same sequence is also run with `pkt_end` moved one cycle later. There the bench expects two descriptors, X and 1, and no error.

// File: rtl/pkt_commit_writer.sv
module pkt_commit_writer #(
  parameter int LEN_W  = 11,
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             pkt_end,
  input  logic [LEN_W-1:0] auto_len,
  input  logic             rd_pop,
  output logic [LEN_W-1:0] desc_len,
  output logic             q_empty,
  output logic             q_full,
  output logic             late_err
);
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QC_W  = $clog2(QDEPTH + 1);

  logic [LEN_W-1:0] cnt, len_q, len_eff, cnt_inc, push_len;
  logic [LEN_W-1:0] slot [QDEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [QC_W-1:0]  qc, qc_nx;
  logic             hit, auto_go, man_go, push, pop;

  assign len_eff  = (cnt == '0) ? ((auto_len == '0) ? LEN_W'(1) : auto_len) : len_q;
  assign cnt_inc  = cnt + LEN_W'(1);
  assign hit      = wr_en && (cnt_inc == len_eff);
  assign auto_go  = hit && !q_full;
  assign man_go   = pkt_end && !q_full && !hit;
  assign push     = auto_go || man_go;
  assign pop      = rd_pop && !q_empty;
  assign push_len = auto_go ? len_eff : (wr_en ? cnt_inc : cnt);
  assign qc_nx    = qc + QC_W'(push) - QC_W'(pop);
  assign desc_len = slot[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      len_q    <= LEN_W'(1);
      wp       <= '0;
      rp       <= '0;
      qc       <= '0;
      q_empty  <= 1'b1;
      q_full   <= 1'b0;
      late_err <= 1'b0;
    end else begin
      if (push) cnt <= '0;
      else if (wr_en && !hit) cnt <= cnt_inc;
      if (cnt == '0) len_q <= len_eff;
      if (push) wp <= (wp == PTR_W'(QDEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (pop)  rp <= (rp == PTR_W'(QDEPTH - 1)) ? '0 : rp + PTR_W'(1);
      qc      <= qc_nx;
      q_empty <= (qc_nx == '0);
      q_full  <= (qc_nx == QC_W'(QDEPTH));
      if (pkt_end && auto_go) late_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= push_len;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_empty && q_full)); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && !rd_pop |=> q_full); // R6
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty && !wr_en && !pkt_end |=> q_empty); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |=> late_err); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_err) |-> $past(pkt_end && wr_en)); // R5
endmodule

// File: tb/pkt_commit_writer_test.sv
module pkt_commit_writer_test;
  localparam int LW = 11;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pkt_end = 1'b0, rd_pop = 1'b0;
  logic [LW-1:0] auto_len = LW'(3);
  logic [LW-1:0] desc_len;
  logic q_empty, q_full, late_err;
  int checks = 0, fails = 0;

  pkt_commit_writer #(.LEN_W(LW), .QDEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pkt_end(pkt_end),
    .auto_len(auto_len), .rd_pop(rd_pop), .desc_len(desc_len),
    .q_empty(q_empty), .q_full(q_full), .late_err(late_err));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic p, input logic pp);
    wr_en = w; pkt_end = p; rd_pop = pp;
    @(negedge clk);
    wr_en = 1'b0; pkt_end = 1'b0; rd_pop = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", int'(q_empty), 1);
    chk("R1 full", int'(q_full), 0);
    chk("R1 err", int'(late_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty after release", int'(q_empty), 1);

    for (int x = 1; x <= 6; x++) begin
      auto_len = LW'(x);
      step(0, 1, 0);
      chk("R4 zero-length commit", int'(desc_len), 0);
      chk("R7 not empty", int'(q_empty), 0);
      step(0, 0, 1);
      chk("R7 empty after pop", int'(q_empty), 1);
      for (int k = 1; k < x; k++) begin
        for (int i = 1; i < k; i++) step(1, 0, 0);
        chk("R3 nothing before end", int'(q_empty), 1);
        step(1, 1, 0);
        chk("R3 short length", int'(desc_len), k);
        step(0, 0, 1);
      end
      for (int i = 1; i < x; i++) step(1, 0, 0);
      chk("R2 no commit before X", int'(q_empty), 1);
      step(1, 0, 0);
      chk("R2 auto length", int'(desc_len), x);
      chk("R2 committed", int'(q_empty), 0);
      step(0, 0, 1);
    end

    auto_len = LW'(3);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    step(1, 1, 0);
    chk("R5 gap auto", int'(desc_len), 3);
    chk("R5 gap no err", int'(late_err), 0);
    step(0, 0, 1);
    chk("R5 gap one byte", int'(desc_len), 1);
    chk("R5 gap one byte present", int'(q_empty), 0);
    step(0, 0, 1);
    chk("R9 drained", int'(q_empty), 1);

    step(1, 0, 0); step(1, 0, 0);
    step(1, 1, 0);
    chk("R5 late auto kept", int'(desc_len), 3);
    chk("R5 late err set", int'(late_err), 1);
    step(0, 0, 1);
    chk("R5 manual dropped", int'(q_empty), 1);
    step(0, 0, 0); step(0, 0, 0);
    chk("R5 err sticky", int'(late_err), 1);

    for (int i = 0; i < 4; i++) begin
      chk("R7 full late", int'(q_full), 0);
      step(1, 1, 0);
    end
    chk("R7 full", int'(q_full), 1);
    step(1, 0, 0); step(1, 0, 0);
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R6 still full", int'(q_full), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 queued len", int'(desc_len), 1);
      step(0, 0, 1);
      chk("R7 full drops", int'(q_full), 0);
    end
    chk("R6 no commit while full", int'(q_empty), 1);
    step(0, 1, 0);
    chk("R6 pending kept", int'(desc_len), 2);
    step(0, 0, 1);

    step(1, 0, 0);
    auto_len = LW'(5);
    step(1, 0, 0); step(1, 0, 0);
    chk("R8 old length used", int'(desc_len), 3);
    step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    chk("R8 new length pending", int'(q_empty), 1);
    step(1, 0, 0);
    chk("R8 new length", int'(desc_len), 5);
    step(0, 0, 1);
    auto_len = '0;
    step(1, 0, 0);
    chk("R8 zero acts as one", int'(desc_len), 1);
    step(0, 0, 1);

    auto_len = LW'(8);
    step(1, 0, 0); step(1, 1, 0);
    step(1, 1, 0);
    step(0, 1, 0);
    chk("R9 first", int'(desc_len), 2);
    step(0, 0, 1);
    chk("R9 second", int'(desc_len), 1);
    step(0, 0, 1);
    chk("R9 third", int'(desc_len), 0);
    step(0, 0, 1);
    chk("R9 empty", int'(q_empty), 1);
    step(0, 0, 1);
    chk("R9 pop on empty", int'(q_empty), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule